// File: doc/BRIEF.md
# Byte-Port 24-Bit Up/Down Counter Channel

One channel of a 24-bit position counter that a host reaches through an 8-bit port with two addresses. The data address moves 24-bit values one byte at a time. Reads take bytes from an output latch that holds a snapshot of the count. Writes put bytes into a preset register. An internal byte pointer selects the byte, starting with the least significant one. The control address takes command bytes. Reading the control address returns a flag byte.

The count source is either a plain pulse input with a level-controlled direction, or a pair of quadrature inputs decoded at one, two or four counts per cycle. The A, B and index inputs each pass through a two-stage synchronizer. An index input with selectable polarity can load the preset value into the counter. A global hold input clears the counter and stops counting, so that every channel on the chip can be held at once.

The byte pointer is a three-state machine: `BP_LOW` selects bits 7:0, `BP_MID` bits 15:8 and `BP_HIGH` bits 23:16. It takes the transition *advance* (LOW→MID, MID→HIGH) and the transition *wrap* (HIGH→LOW) on each data-address read or write. It takes the transition *rewind* (any state→LOW) on a reset-pointer command.

Top module: `qc_channel`

## Requirements
- R1: A control write routes by bits 7:5 of the byte: 000 is a command, 001 sets the mode (bits 4:3 pick resolution: 00 pulse, 01 x1, 10 x2, 11 x4), 010 sets the input control (bit 0 enables counting, bit 1 enables preset load on index), 011 sets the index control (bit 0 enables index, bit 1 = 1 means active-high, 0 means active-low). All start at zero after reset.
- R2: The byte pointer selects bits 7:0, then 15:8, then 23:16, and wraps back to bits 7:0. It advances on every data-address read or write. Command bit 0 returns it to bits 7:0.
- R3: A data-address write stores the byte into the preset register at the pointer. Command bit 3 (0x08) copies the preset into the counter.
- R4: Command bit 4 (0x10) copies the counter into the output latch. The latch is read byte by byte at the data address. The command bits combine, so 0x11 rewinds the pointer and latches in one write.
- R5: Command bits 2:1 clear state: 01 (0x02) clears the counter, 10 (0x04) clears both toggles, 11 (0x06) clears the error flag. A preset load in the same byte takes priority over the clear.
- R6: The control-address read returns the borrow toggle in bit 0, the carry toggle in bit 1, the error flag in bit 4 and the last count direction in bit 5 (1 = up). All other bits are 0.
- R7: A count down from 0 gives 0xFFFFFF and flips the borrow toggle. A count up from 0xFFFFFF gives 0 and flips the carry toggle.
- R8: In pulse mode, each rising edge of A counts once: up while B is 1, down while B is 0. No input counts while input-control bit 0 is clear. Apart from loads and clears, the counter moves by at most 1 per cycle.
- R9: In quadrature modes, with phase order AB 00→10→11→01→00 counting up: x4 counts every valid transition, x2 counts only A transitions, and x1 counts only the 00↔10 transitions.
- R10: In quadrature modes, when A and B change in the same sample, the error flag is set and the count does not move. The error flag stays set until it is cleared by command.
- R11: With the index enabled and input-control bit 1 set, the step of the synchronized index into its active level loads the preset into the counter. With the index disabled, the index input has no effect.
- R12: While the global hold input is 1, the counter is 0 and ignores count inputs and preset loads.
- R13: After reset, the counter, latch, preset, flags and pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_ctl | input | 1 | Address select: 1 = control, 0 = data |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Latch byte at the pointer (data) or flag byte (control) |
| glb_hold | input | 1 | Shared hold: clears and stops the counter |
| cnt_a | input | 1 | Count pulse or quadrature phase A |
| cnt_b | input | 1 | Direction level or quadrature phase B |
| cnt_idx | input | 1 | Index input |

## Verification
The in-RTL properties check the per-cycle rules on every cycle:
- the pointer's wrap and rewind transitions;
- the latch capturing the previous count;
- the counter moving by at most one outside loads;
- the carry toggle staying stable unless it wraps or is cleared;
- the error flag staying set;
- the hold forcing zero.

The values themselves need the bench's scenarios:
- least-significant-first byte order;
- preset transfer;
- the exact x1/x2/x4 counts for forward and reverse phase sequences;
- wrap-around toggles;
- index polarity;
- command priority.

Those are compared against a behavioural model on every clock and with hand-computed read-backs.

// File: rtl/qc_pkg.sv
package qc_pkg;
    localparam int unsigned QC_CNT_W = 24;
    localparam int unsigned QC_LANES = QC_CNT_W / 8;

    typedef enum logic [1:0] {
        BP_LOW  = 2'd0,
        BP_MID  = 2'd1,
        BP_HIGH = 2'd2
    } bptr_t;

    typedef enum logic [1:0] {
        RES_PULSE = 2'd0,
        RES_X1    = 2'd1,
        RES_X2    = 2'd2,
        RES_X4    = 2'd3
    } res_t;

    typedef enum logic [2:0] {
        TGT_CMD   = 3'b000,
        TGT_MODE  = 3'b001,
        TGT_IO    = 3'b010,
        TGT_INDEX = 3'b011
    } tgt_t;

    typedef struct packed {
        logic ptr_rst;
        logic cnt_clr;
        logic flg_clr;
        logic err_clr;
        logic load;
        logic latch;
    } cmd_t;
endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_old
);
    logic [STAGES:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i <= STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q     = pipe[STAGES-1];
    assign q_old = pipe[STAGES];
endmodule

// File: rtl/qc_step_decode.sv
module qc_step_decode
    import qc_pkg::*;
(
    input  res_t res,
    input  logic a_cur,
    input  logic a_old,
    input  logic b_cur,
    input  logic b_old,
    output logic step,
    output logic up,
    output logic bad
);
    logic a_chg, b_chg;

    assign a_chg = a_cur ^ a_old;
    assign b_chg = b_cur ^ b_old;
    assign bad   = (res != RES_PULSE) && a_chg && b_chg;

    always_comb begin
        unique case (res)
            RES_PULSE: begin
                step = a_cur & ~a_old;
                up   = b_cur;
            end
            RES_X1: begin
                step = a_chg & ~b_chg & ~b_cur;
                up   = a_cur;
            end
            RES_X2: begin
                step = a_chg & ~b_chg;
                up   = a_cur ^ b_cur;
            end
            default: begin
                step = a_chg ^ b_chg;
                up   = a_cur ^ b_old;
            end
        endcase
    end
endmodule

// File: rtl/qc_byte_port.sv
module qc_byte_port
    import qc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic [7:0]          wbyte,
    input  logic                ptr_rst,
    input  logic                latch_req,
    input  logic [QC_CNT_W-1:0] cnt_in,
    output logic [QC_CNT_W-1:0] preset_o,
    output logic [7:0]          rbyte
);
    bptr_t               ptr_q, ptr_nx;
    logic [QC_CNT_W-1:0] latch_q;
    logic                acc;

    assign acc = acc_wr | acc_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= BP_LOW;
        else        ptr_q <= ptr_nx;
    end

    // transitions: advance, wrap, rewind
    always_comb begin
        ptr_nx = ptr_q;
        if (ptr_rst) begin
            ptr_nx = BP_LOW;
        end else if (acc) begin
            unique case (ptr_q)
                BP_LOW:  ptr_nx = BP_MID;
                BP_MID:  ptr_nx = BP_HIGH;
                BP_HIGH: ptr_nx = BP_LOW;
                default: ptr_nx = BP_LOW;
            endcase
        end
    end

    for (genvar g = 0; g < QC_LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                preset_o[g*8 +: 8] <= '0;
            else if (acc_wr && (ptr_q == bptr_t'(g)))
                preset_o[g*8 +: 8] <= wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latch_q <= '0;
        else if (latch_req) latch_q <= cnt_in;
    end

    // output process
    always_comb begin
        unique case (ptr_q)
            BP_LOW:  rbyte = latch_q[7:0];
            BP_MID:  rbyte = latch_q[15:8];
            BP_HIGH: rbyte = latch_q[23:16];
            default: rbyte = 8'h00;
        endcase
    end

    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ptr_rst && ptr_q == BP_HIGH) |=> (ptr_q == BP_LOW));
    p_ptr_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (ptr_q == BP_LOW));
    p_latch_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (latch_q == $past(cnt_in)));
endmodule

// File: rtl/qc_channel.sv
module qc_channel
    import qc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_ctl,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       glb_hold,
    input  logic       cnt_a,
    input  logic       cnt_b,
    input  logic       cnt_idx
);
    localparam logic [QC_CNT_W-1:0] CNT_MAX = '1;

    logic                ctl_wr;
    tgt_t                tgt;
    cmd_t                cmd;
    logic [1:0]          mode_q, io_q, idx_q;
    logic [QC_CNT_W-1:0] cnt_q, preset;
    logic                bt_q, ct_q, err_q, dir_q;
    logic [2:0]          s_now, s_old;
    logic                step, up, bad;
    logic                cnt_en, adv, idx_evt, idx_load, override;
    logic                act_now, act_old;
    logic [7:0]          port_byte;

    assign ctl_wr = bus_wr & bus_ctl;
    assign tgt    = tgt_t'(bus_wdata[7:5]);

    always_comb begin
        cmd = '0;
        if (ctl_wr && tgt == TGT_CMD) begin
            cmd.ptr_rst = bus_wdata[0];
            cmd.load    = bus_wdata[3];
            cmd.latch   = bus_wdata[4];
            cmd.cnt_clr = (bus_wdata[2:1] == 2'b01);
            cmd.flg_clr = (bus_wdata[2:1] == 2'b10);
            cmd.err_clr = (bus_wdata[2:1] == 2'b11);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            io_q   <= '0;
            idx_q  <= '0;
        end else if (ctl_wr) begin
            unique case (tgt)
                TGT_MODE:  mode_q <= bus_wdata[4:3];
                TGT_IO:    io_q   <= bus_wdata[1:0];
                TGT_INDEX: idx_q  <= bus_wdata[1:0];
                default:   ;
            endcase
        end
    end

    qc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cnt_idx, cnt_b, cnt_a}),
        .q(s_now), .q_old(s_old)
    );

    qc_step_decode u_dec (
        .res(res_t'(mode_q)), .a_cur(s_now[0]), .a_old(s_old[0]),
        .b_cur(s_now[1]), .b_old(s_old[1]),
        .step(step), .up(up), .bad(bad)
    );

    assign cnt_en   = io_q[0] & ~glb_hold;
    assign adv      = cnt_en & step;
    assign act_now  = idx_q[1] ? s_now[2] : ~s_now[2];
    assign act_old  = idx_q[1] ? s_old[2] : ~s_old[2];
    assign idx_evt  = idx_q[0] & act_now & ~act_old;
    assign idx_load = idx_evt & io_q[1];
    assign override = glb_hold | cmd.load | cmd.cnt_clr | idx_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bt_q  <= 1'b0;
            ct_q  <= 1'b0;
            err_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            if (glb_hold)          cnt_q <= '0;
            else if (cmd.load)     cnt_q <= preset;
            else if (cmd.cnt_clr)  cnt_q <= '0;
            else if (idx_load)     cnt_q <= preset;
            else if (adv)          cnt_q <= up ? cnt_q + 1'b1 : cnt_q - 1'b1;

            if (cmd.flg_clr) begin
                bt_q <= 1'b0;
                ct_q <= 1'b0;
            end else if (adv && !override) begin
                bt_q <= bt_q ^ (~up & (cnt_q == '0));
                ct_q <= ct_q ^ (up & (cnt_q == CNT_MAX));
            end

            if (cmd.err_clr)          err_q <= 1'b0;
            else if (bad && cnt_en)   err_q <= 1'b1;

            if (adv) dir_q <= up;
        end
    end

    qc_byte_port u_port (
        .clk(clk), .rst_n(rst_n),
        .acc_wr(bus_wr & ~bus_ctl), .acc_rd(bus_rd & ~bus_ctl),
        .wbyte(bus_wdata), .ptr_rst(cmd.ptr_rst), .latch_req(cmd.latch),
        .cnt_in(cnt_q), .preset_o(preset), .rbyte(port_byte)
    );

    assign bus_rdata = bus_ctl ? {2'b00, dir_q, err_q, 2'b00, ct_q, bt_q} : port_byte;

    p_hold_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        glb_hold |=> (cnt_q == '0));
    p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_hold && !cmd.load && !cmd.cnt_clr && !idx_load) |=>
        (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1));
    p_carry_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.flg_clr && !(adv && up && cnt_q == CNT_MAX)) |=> $stable(ct_q));
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !cmd.err_clr) |=> err_q);
endmodule

// File: tb/qc_channel_tb.sv
module qc_channel_tb;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0, bus_ctl = 1;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic glb_hold = 0, cnt_a = 0, cnt_b = 0, cnt_idx = 1;

    int n_chk = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    qc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ctl(bus_ctl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glb_hold(glb_hold), .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_idx(cnt_idx)
    );

    // behavioural reference model
    int m_cnt, m_pre, m_lat, m_ptr, m_res, m_io, m_ix;
    bit m_bt, m_ct, m_err, m_dir;
    bit ha[3], hb[3], hi[3];

    function automatic int gpos(bit a, bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_lat = 0; m_ptr = 0; m_res = 0; m_io = 0; m_ix = 0;
            m_bt = 0; m_ct = 0; m_err = 0; m_dir = 0;
            for (int i = 0; i < 3; i++) begin ha[i] = 0; hb[i] = 0; hi[i] = 0; end
        end else begin
            int d, stp, dn, nc;
            bit ld, clr, ilo, en, bad, an, ao;
            bit [7:0] w;
            w = bus_wdata;
            d = (gpos(ha[1], hb[1]) - gpos(ha[2], hb[2]) + 4) % 4;
            stp = 0; bad = 0;
            case (m_res)
                0: if (ha[1] && !ha[2]) stp = hb[1] ? 1 : -1;
                1: if (gpos(ha[2], hb[2]) == 0 && gpos(ha[1], hb[1]) == 1) stp = 1;
                   else if (gpos(ha[2], hb[2]) == 1 && gpos(ha[1], hb[1]) == 0) stp = -1;
                2: if (ha[1] != ha[2] && hb[1] == hb[2]) stp = (d == 1) ? 1 : -1;
                default: if (d == 1) stp = 1; else if (d == 3) stp = -1;
            endcase
            if (m_res != 0 && d == 2) bad = 1;
            en = m_io[0] && !glb_hold;
            if (!en) stp = 0;
            ld = 0; clr = 0;
            if (bus_wr && bus_ctl && w[7:5] == 3'b000) begin
                ld = w[3]; clr = (w[2:1] == 2'b01);
            end
            an = m_ix[1] ? hi[1] : !hi[1];
            ao = m_ix[1] ? hi[2] : !hi[2];
            ilo = m_ix[0] && an && !ao && m_io[1];
            nc = m_cnt;
            if (glb_hold) nc = 0;
            else if (ld) nc = m_pre;
            else if (clr) nc = 0;
            else if (ilo) nc = m_pre;
            else if (stp != 0) begin
                dn = m_cnt + stp;
                if (dn < 0)         begin dn = 24'hFFFFFF; m_bt = !m_bt; end
                if (dn > 24'hFFFFFF) begin dn = 0; m_ct = !m_ct; end
                nc = dn;
            end
            if (stp != 0) m_dir = (stp > 0);
            if (bad && en) m_err = 1;
            if (bus_wr && bus_ctl) begin
                case (w[7:5])
                    3'b000: begin
                        if (w[2:1] == 2'b10) begin m_bt = 0; m_ct = 0; end
                        if (w[2:1] == 2'b11) m_err = 0;
                        if (w[4]) m_lat = m_cnt;
                        if (w[0]) m_ptr = 0;
                    end
                    3'b001: m_res = w[4:3];
                    3'b010: m_io = w[1:0];
                    3'b011: m_ix = w[1:0];
                    default: ;
                endcase
            end
            if (!bus_ctl && (bus_wr || bus_rd)) begin
                if (bus_wr) begin
                    m_pre = m_pre & ~(32'hFF << (8*m_ptr));
                    m_pre = m_pre | (int'(w) << (8*m_ptr));
                end
                m_ptr = (m_ptr + 1) % 3;
            end
            m_cnt = nc;
            for (int i = 2; i > 0; i--) begin ha[i] = ha[i-1]; hb[i] = hb[i-1]; hi[i] = hi[i-1]; end
            ha[0] = cnt_a; hb[0] = cnt_b; hi[0] = cnt_idx;
        end
    end

    function automatic bit [7:0] m_rdata();
        if (bus_ctl) return {2'b00, m_dir, m_err, 2'b00, m_ct, m_bt};
        return 8'((m_lat >> (8*m_ptr)) & 8'hFF);
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (bus_rdata !== m_rdata()) begin
                n_fail++;
                $display("FAIL %s model compare: actual %02h expected %02h",
                         bus_ctl ? "R6" : "R2", bus_rdata, m_rdata());
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input bit ctl, input bit [7:0] v);
        bus_wr = 1; bus_ctl = ctl; bus_wdata = v;
        @(posedge clk); #2;
        bus_wr = 0; bus_ctl = 1;
    endtask

    task automatic rd_byte(output bit [7:0] v);
        bus_rd = 1; bus_ctl = 0;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #2;
        bus_rd = 0; bus_ctl = 1;
    endtask

    task automatic check_cnt(input string tag, input int exp);
        bit [7:0] b0, b1, b2;
        wr(1, 8'h11);
        rd_byte(b0); rd_byte(b1); rd_byte(b2);
        check(tag, {8'h00, b2, b1, b0}, exp);
    endtask

    task automatic check_flags(input string tag, input bit [7:0] exp);
        bus_ctl = 1;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        @(posedge clk); #2;
    endtask

    task automatic pulse_a(input int n);
        repeat (n) begin cnt_a = 1; idle(3); cnt_a = 0; idle(3); end
        idle(3);
    endtask

    task automatic set_ab(input bit a, input bit b);
        cnt_a = a; cnt_b = b; idle(4);
    endtask

    task automatic pulse_idx(input bit active);
        cnt_idx = active; idle(3); cnt_idx = !active; idle(4);
    endtask

    task automatic write_preset(input bit [23:0] v);
        wr(1, 8'h01); wr(0, v[7:0]); wr(0, v[15:8]); wr(0, v[23:16]);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        bit [7:0] b;
        idle(3); rst_n = 1; idle(2);
        // R13 reset state
        check_flags("R13 flags", 8'h00);
        check_cnt("R13 count", 0);
        // R1 / R8 pulse mode
        wr(1, 8'h41); cnt_b = 1; idle(2);
        pulse_a(5); check_cnt("R8 up pulses", 5);
        cnt_b = 0; idle(2); pulse_a(3); check_cnt("R8 down pulses", 2);
        check_flags("R6 dir down", 8'h00);
        wr(1, 8'h40); pulse_a(2); check_cnt("R8 disabled ignored", 2);
        // R3 preset and R2 byte order
        write_preset(24'h123456); wr(1, 8'h08);
        check_cnt("R3 preset transfer", 24'h123456);
        rd_byte(b); check("R2 pointer wrap", b, 8'h56);
        // R5 clear counter
        wr(1, 8'h02); check_cnt("R5 clear counter", 0);
        // R7 borrow / carry
        wr(1, 8'h41); cnt_b = 0; idle(2); pulse_a(1);
        check_cnt("R7 underflow", 24'hFFFFFF);
        check_flags("R7 borrow toggle", 8'h01);
        cnt_b = 1; idle(2); pulse_a(1);
        check_cnt("R7 overflow", 0);
        check_flags("R7 carry toggle", 8'h23);
        wr(1, 8'h04); check_flags("R5 clear toggles", 8'h20);
        // R9 quadrature
        wr(1, 8'h02); cnt_b = 0; idle(4);
        wr(1, 8'h38);
        set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
        check_cnt("R9 x4 forward", 4);
        wr(1, 8'h30);
        set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
        check_cnt("R9 x2 forward", 6);
        wr(1, 8'h28);
        set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0);
        check_cnt("R9 x1 forward", 7);
        wr(1, 8'h38);
        set_ab(0,1); set_ab(1,1); set_ab(1,0); set_ab(0,0);
        check_cnt("R9 x4 reverse", 3);
        // R10 invalid transition
        set_ab(1,1);
        check_flags("R10 error set", 8'h10);
        check_cnt("R10 count held", 3);
        set_ab(1,0); set_ab(0,0);
        check_cnt("R10 count after", 1);
        check_flags("R10 error sticky", 8'h10);
        wr(1, 8'h06); check_flags("R5 clear error", 8'h00);
        // R11 index
        wr(1, 8'h20); write_preset(24'h000100);
        wr(1, 8'h43); wr(1, 8'h61); idle(2);
        pulse_idx(0); check_cnt("R11 index active-low", 24'h000100);
        wr(1, 8'h60); wr(1, 8'h02); pulse_idx(0);
        check_cnt("R11 index disabled", 0);
        cnt_idx = 0; idle(4); wr(1, 8'h63); wr(1, 8'h02);
        pulse_idx(1); check_cnt("R11 index active-high", 24'h000100);
        // R12 global hold
        wr(1, 8'h02); cnt_b = 1; idle(2); pulse_a(2);
        check_cnt("R12 before hold", 2);
        glb_hold = 1; idle(2); pulse_a(2); wr(1, 8'h08); idle(2);
        check_cnt("R12 held at zero", 0);
        glb_hold = 0; idle(2); pulse_a(1);
        check_cnt("R12 released", 1);
        idle(4);
        summary();
        $finish;
    end
endmodule